// File: doc/BRIEF.md
# Bus-Programmed Reloading Countdown Timer

This block is a countdown timer reached through an APB slave port. Software programs a start value and a reload value and then enables counting. Each counting step, called a tick below, takes the count one step down. A tick that arrives while the count is zero does something different: it loads the reload value and sets an interrupt status flag. With a reload value of R, the flag therefore sets once every R+1 ticks. An interrupt output follows the flag, but only while a mask bit in the control register lets it through.

Ticks come from one of three sources. In the plain mode every bus clock is a tick. In the gated mode a bus clock is a tick only while an external input is high. In the external clock mode each rising edge of that input is a tick. The external input is first passed through a flop synchroniser, and rising edges are detected after the synchroniser. The status flag has a single location: reading it returns the flag, and writing a one there clears it.

Top module: `apb_countdown_timer`

## Requirements
- R1: After reset, the control, count, reload and status locations all read zero, and `irq_o` is low.
- R2: The word offsets are control 0x0, count 0x4, reload 0x8 and status 0xC. The first three read back what was written. Control holds only bits 3:0, and its unused bits read zero. Any other address, including one that is not word aligned, reads zero and ignores writes. `pready` is always 1 and `pslverr` is always 0.
- R3: With control bit 0 set and bits 1 and 2 clear, the count drops by one on every clock.
- R4: A tick while the count is zero loads the reload value and sets the status flag. The flag reads back as bit 0 of offset 0xC.
- R5: With control bits 0 and 1 set and bit 2 clear, a tick happens only on clocks where the synchronised input is high.
- R6: With control bits 0 and 2 set, there is exactly one tick for each rising edge of the synchronised input, however long the input then stays high.
- R7: `irq_o` equals the status flag ANDed with control bit 3. The flag still sets while bit 3 is clear.
- R8: Writing 1 to bit 0 of offset 0xC clears the flag. Writing 0 there leaves the flag unchanged.
- R9: If a clear write and a flag-setting tick fall in the same cycle, the flag stays set.
- R10: A write to offset 0x4 replaces the count in the cycle of the write, and any tick in that same cycle is discarded.
- R11: While control bit 0 is clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, registered in the setup phase |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| ext_in | input | 1 | Asynchronous external gate or clock input |
| irq_o | output | 1 | Masked interrupt request |

## Verification
On every cycle the assertions check the following. The count either steps down by one, reloads at zero, takes the value written to it, or holds. A clear write loses to a flag-setting tick in the same cycle. `irq_o` is never high while the mask is clear or the flag is low. The edge detector never reports two rising edges on consecutive cycles. Only the bench's scenarios show the end-to-end results: how many ticks each source mode produces over a known input pattern, what the count holds after a run, register readback, and that unmapped addresses read zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Control bit positions; software depends on these.
  localparam int CTRL_W = 4;

  typedef struct packed {
    logic irq_en;    // bit 3
    logic ext_clk;   // bit 2
    logic ext_gate;  // bit 1
    logic run;       // bit 0
  } ctrl_t;

  // Word select taken from address bits 3:2
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_FLAG   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  // A chain of at least two flops, then one more flop for edge detection.
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic at_zero;

  assign at_zero = (count == '0);
  // A bus write to the count takes priority and swallows this cycle's tick.
  assign wrap    = tick & ~load_en & at_zero;

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (load_en) count <= load_val;
    else if (tick)    count <= at_zero ? reload_val : count - 1'b1;
  end
endmodule

// File: rtl/tmr_apb_regs.sv
module tmr_apb_regs
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrap,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              flag,
  output logic              val_wr,
  output logic [CNT_W-1:0]  val_data,
  output logic              clr_wr
);
  localparam int HI_W = ADDR_W - 4;

  logic        in_range;
  reg_sel_e    sel;
  logic        wr_acc;
  logic        rd_setup;
  logic [DATA_W-1:0] rd_mux;

  assign in_range = (paddr[ADDR_W-1:4] == HI_W'(0)) && (paddr[1:0] == 2'b00);
  assign sel      = reg_sel_e'(paddr[3:2]);
  assign wr_acc   = psel & penable & pwrite & in_range;
  assign rd_setup = psel & ~penable & ~pwrite;

  assign val_wr   = wr_acc && (sel == SEL_COUNT);
  assign val_data = pwdata[CNT_W-1:0];
  assign clr_wr   = wr_acc && (sel == SEL_FLAG) && pwdata[0];

  always_comb begin
    rd_mux = '0;
    if (in_range) begin
      unique case (sel)
        SEL_CTRL:   rd_mux = DATA_W'(ctrl);
        SEL_COUNT:  rd_mux = DATA_W'(count);
        SEL_RELOAD: rd_mux = DATA_W'(reload);
        SEL_FLAG:   rd_mux = DATA_W'(flag);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= '0;
      flag   <= 1'b0;
      prdata <= '0;
    end else begin
      if (wr_acc && sel == SEL_CTRL)   ctrl   <= ctrl_t'(pwdata[CTRL_W-1:0]);
      if (wr_acc && sel == SEL_RELOAD) reload <= pwdata[CNT_W-1:0];
      // Setting beats clearing in the same cycle.
      if (wrap)        flag <= 1'b1;
      else if (clr_wr) flag <= 1'b0;
      // Read data is captured in the setup phase, valid through the access phase.
      if (rd_setup) prdata <= rd_mux;
    end
  end
endmodule

// File: rtl/apb_countdown_timer.sv
module apb_countdown_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              ext_in,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] val_data;
  logic             flag;
  logic             val_wr;
  logic             clr_wr;
  logic             wrap;
  logic             tick;
  logic             ext_level;
  logic             ext_rise;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_in),
    .level    (ext_level),
    .rise     (ext_rise)
  );

  // Tick source: the edge mode overrides the gated mode.
  always_comb begin
    if (!ctrl.run)         tick = 1'b0;
    else if (ctrl.ext_clk) tick = ext_rise;
    else if (ctrl.ext_gate) tick = ext_level;
    else                   tick = 1'b1;
  end

  tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .load_en    (val_wr),
    .load_val   (val_data),
    .reload_val (reload),
    .count      (count),
    .wrap       (wrap)
  );

  tmr_apb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .count    (count),
    .wrap     (wrap),
    .ctrl     (ctrl),
    .reload   (reload),
    .flag     (flag),
    .val_wr   (val_wr),
    .val_data (val_data),
    .clr_wr   (clr_wr)
  );

  assign irq_o = flag & ctrl.irq_en;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             val_wr,
  input logic [CNT_W-1:0] val_data,
  input logic             clr_wr,
  input logic             flag,
  input logic             irq_en,
  input logic             irq_o,
  input logic             ext_rise,
  input logic             pready,
  input logic             pslverr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload
);
  assert_bus_ok_R2: assert property (@(posedge clk) disable iff (rst)
    pready && !pslverr);

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !val_wr && count != '0) |=> count == $past(count) - 1'b1);

  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !val_wr && count == '0) |=> (count == $past(reload)) && flag);

  assert_one_edge_R6: assert property (@(posedge clk) disable iff (rst)
    ext_rise |=> !ext_rise);

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag);

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq_o);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !(tick && !val_wr && count == '0)) |=> !flag);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && tick && !val_wr && count == '0) |=> flag);

  assert_load_R10: assert property (@(posedge clk) disable iff (rst)
    val_wr |=> count == $past(val_data));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!tick && !val_wr) |=> $stable(count));
endmodule

bind apb_countdown_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .val_wr   (val_wr),
  .val_data (val_data),
  .clr_wr   (clr_wr),
  .flag     (flag),
  .irq_en   (ctrl.irq_en),
  .irq_o    (irq_o),
  .ext_rise (ext_rise),
  .pready   (pready),
  .pslverr  (pslverr),
  .count    (count),
  .reload   (reload)
);

// File: tb/tb_apb_countdown_timer.sv
module tb_apb_countdown_timer;
  localparam int CLK_P = 10;
  localparam logic [11:0] A_CTRL = 12'h000, A_CNT = 12'h004,
                          A_RLD = 12'h008, A_STAT = 12'h00C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, ext_in = 1'b0, irq_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  apb_countdown_timer dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .ext_in(ext_in), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        rd;    // 1: read and compare, 0: write
    logic [11:0] addr;
    logic [31:0] data;  // write data or expected read data
  } vec_t;

  // R2 register access table, run with counting disabled.
  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0, A_CTRL, 32'hFFFF_FFF6},
    '{1'b1, A_CTRL, 32'h0000_0006},
    '{1'b0, A_RLD,  32'h1234_5678},
    '{1'b1, A_RLD,  32'h1234_5678},
    '{1'b0, A_CNT,  32'hCAFE_0001},
    '{1'b1, A_CNT,  32'hCAFE_0001},
    '{1'b1, A_STAT, 32'h0000_0000},
    '{1'b0, 12'h010, 32'hFFFF_FFFF},
    '{1'b1, 12'h010, 32'h0000_0000},
    '{1'b0, 12'h009, 32'h0000_0001},
    '{1'b1, A_CTRL, 32'h0000_0006},
    '{1'b1, A_RLD,  32'h1234_5678},
    '{1'b0, A_CTRL, 32'h0000_0000},
    '{1'b1, A_CTRL, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); d = prdata; psel = 1'b0; penable = 1'b0;
  endtask

  task automatic prep(input logic [31:0] start);
    apb_wr(A_CTRL, 32'h0);
    apb_wr(A_CNT, start);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    apb_rd(A_CTRL, rv); check("R1 ctrl", rv, 0);
    apb_rd(A_CNT,  rv); check("R1 count", rv, 0);
    apb_rd(A_RLD,  rv); check("R1 reload", rv, 0);
    apb_rd(A_STAT, rv); check("R1 status", rv, 0);
    check("R1 irq_o", {31'b0, irq_o}, 0);
    check("R2 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);

    // R2 table walk
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].rd) begin
        apb_rd(TBL[i].addr, rv);
        check($sformatf("R2 table[%0d]", i), rv, TBL[i].data);
      end else begin
        apb_wr(TBL[i].addr, TBL[i].data);
      end
    end

    // R3 free running: 4 idle cycles between two writes gives 7 ticks
    prep(100);
    apb_wr(A_CTRL, 32'h1);
    repeat (4) @(negedge clk);
    apb_wr(A_CTRL, 32'h0);
    apb_rd(A_CNT, rv); check("R3 free count", rv, 93);
    // R11 hold while disabled
    repeat (10) @(negedge clk);
    apb_rd(A_CNT, rv); check("R11 hold", rv, 93);

    // R5 gated: input high for 6 cycles
    prep(100);
    apb_wr(A_CTRL, 32'h3);
    repeat (4) @(negedge clk);
    ext_in = 1'b1;
    repeat (6) @(negedge clk);
    ext_in = 1'b0;
    repeat (8) @(negedge clk);
    apb_wr(A_CTRL, 32'h0);
    apb_rd(A_CNT, rv); check("R5 gated count", rv, 94);

    // R6 edge mode: 4 short pulses and one long pulse
    prep(100);
    apb_wr(A_CTRL, 32'h5);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); ext_in = 1'b1;
      repeat (2) @(negedge clk); ext_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    @(negedge clk); ext_in = 1'b1;
    repeat (10) @(negedge clk); ext_in = 1'b0;
    repeat (8) @(negedge clk);
    apb_wr(A_CTRL, 32'h0);
    apb_rd(A_CNT, rv); check("R6 edge count", rv, 95);

    // R4 reload with reload=3, 7 ticks from zero: 3,2,1,0,3,2,1
    apb_wr(A_STAT, 32'h1);
    apb_wr(A_RLD, 32'h3);
    prep(0);
    apb_wr(A_CTRL, 32'h1);
    repeat (4) @(negedge clk);
    apb_wr(A_CTRL, 32'h0);
    apb_rd(A_CNT, rv);  check("R4 reload sequence", rv, 1);
    apb_rd(A_STAT, rv); check("R4 flag set", rv, 1);
    check("R7 masked irq", {31'b0, irq_o}, 0);
    apb_wr(A_CTRL, 32'h8);
    check("R7 unmasked irq", {31'b0, irq_o}, 1);

    // R8 write 0 keeps flag, write 1 clears
    apb_wr(A_STAT, 32'h0);
    apb_rd(A_STAT, rv); check("R8 write zero", rv, 1);
    apb_wr(A_STAT, 32'h1);
    apb_rd(A_STAT, rv); check("R8 cleared", rv, 0);
    check("R8 irq low", {31'b0, irq_o}, 0);

    // R9 reload=0 flags on every tick; clear during run must lose
    apb_wr(A_RLD, 32'h0);
    prep(0);
    apb_wr(A_CTRL, 32'h9);
    apb_wr(A_STAT, 32'h1);
    check("R9 set wins", {31'b0, irq_o}, 1);
    apb_wr(A_CTRL, 32'h8);
    apb_wr(A_STAT, 32'h1);
    check("R8 clear when idle", {31'b0, irq_o}, 0);

    // R10 count write while running: one tick after the write, before capture
    prep(32'h1000);
    apb_wr(A_CTRL, 32'h1);
    apb_wr(A_CNT, 32'd50);
    apb_rd(A_CNT, rv); check("R10 overwrite", rv, 49);
    apb_wr(A_CTRL, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule